// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O peripheral on an APB slave interface. It has up to four ports, and all ports have the same configurable width. Each port has a writable output value, a writable output-enable mask and a read-only view of its synchronized input pins. Software drives pins by setting the output value and the output enable, and reads pin states through the input view.

The first port can also raise interrupts. Each of its pins can be enabled, masked, made edge- or level-sensitive, given a polarity and, optionally, debounced. Edge events are latched until software clears them by writing ones to an end-of-interrupt register. Level events follow the pin and are not latched. All unmasked pending events are combined into a single interrupt line. A parameter moves five of the interrupt registers to an alternate offset map.

Top module: `gpio_apb_irq`

## Requirements
- R1: After a synchronous active-low reset, every data, direction and interrupt-configuration register reads 0, `gpio_oe` and `gpio_out` are all 0, and `irq` is 0.
- R2: Port p has its output-value register at byte offset 12*p and its output-enable register at 12*p+4. Each register drives its slice `[p*PORT_W +: PORT_W]` of `gpio_out` and `gpio_oe` from the cycle after the write, and reads back the value written.
- R3: Reading offset 0x50+4*p returns port p's pins after a two-flop synchronizer. The value is zero-extended to 32 bits.
- R4: In the type register, bit value 1 makes a pin edge-sensitive and 0 makes it level-sensitive. In the polarity register, 1 selects a rising edge or a high level, and 0 selects a falling edge or a low level. An edge of the opposite polarity raises nothing.
- R5: The status register returns (pending AND enable AND NOT mask) for each port-0 pin. `irq` is 1 exactly when some status bit is 1.
- R6: A mask bit of 1 removes that pin from status and from `irq`. The pin stays enabled, so clearing the mask brings a still-active event back.
- R7: An enabled edge event stays pending after the pin returns to its idle level.
- R8: Writing ones to the end-of-interrupt register clears the pending edge of exactly those pins. Bits written as 0 leave their edges pending. If a new edge arrives in the same cycle as the clear, the edge wins.
- R9: A level event is not latched. It follows the pin, and an end-of-interrupt write has no effect on it.
- R10: Clearing a pin's enable bit discards its pending edge, so enabling the pin again shows no event.
- R11: With the debounce bit set, a port-0 pin must differ from its accepted level for DEB_CYCLES consecutive `deb_tick` pulses before the new level is accepted. Shorter glitches raise no event.
- R12: With ALT_MAP=0, the interrupt registers are enable 0x30, mask 0x34, type 0x38, polarity 0x3c, status 0x40, debounce 0x48 and end-of-interrupt 0x4c. With ALT_MAP=1, type moves to 0x34, polarity to 0x38, status to 0x3c, end-of-interrupt to 0x40 and mask to 0x44.
- R13: Registers of ports at or above NUM_PORTS read 0 and ignore writes. A write to a narrow port keeps only its low PORT_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 7 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| deb_tick | input | 1 | One-cycle pulse that advances the debounce counters |
| gpio_in | input | NUM_PORTS*PORT_W | Raw input pins |
| gpio_out | output | NUM_PORTS*PORT_W | Output values |
| gpio_oe | output | NUM_PORTS*PORT_W | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds two instances. The first uses the defaults: four 32-bit ports, the standard map and DEB_CYCLES=4, with `deb_tick` held high so that the debounce window is four clocks. This reaches the port strides, every trigger kind and glitch rejection. The second uses ALT_MAP=1 with two 8-bit ports. Its type and mask offsets would collide with the standard map, so it shows the alternate decode. It also covers absent ports and the truncation of writes to a narrow port.

// File: rtl/gpio_apb_pkg.sv
// Package of shared types for the GPIO controller.
// It holds the register kinds and the address decoder for both offset maps.
// Assumes word-aligned byte addresses and at most four ports.
package gpio_apb_pkg;

    localparam int ADDR_W    = 7;
    localparam int BUS_W     = 32;
    localparam int MAX_PORTS = 4;

    typedef enum logic [3:0] {
        RK_NONE, RK_DATA, RK_DIR, RK_PINS,
        RK_IEN, RK_IMASK, RK_ITYPE, RK_IPOL, RK_ISTAT, RK_IDEB, RK_IEOI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [1:0]  port;
    } reg_sel_t;

    // Map a byte address to a register kind and a port index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a, input bit alt);
        reg_sel_t r;
        r.kind = RK_NONE;
        r.port = '0;
        for (int p = 0; p < MAX_PORTS; p++) begin
            if (a == ADDR_W'(12*p))       begin r.kind = RK_DATA; r.port = 2'(p); end
            if (a == ADDR_W'(12*p + 4))   begin r.kind = RK_DIR;  r.port = 2'(p); end
            if (a == ADDR_W'(80 + 4*p))   begin r.kind = RK_PINS; r.port = 2'(p); end
        end
        case (a)
            7'h30:   r.kind = RK_IEN;
            7'h48:   r.kind = RK_IDEB;
            default: ;
        endcase
        if (alt) begin
            case (a)
                7'h34:   r.kind = RK_ITYPE;
                7'h38:   r.kind = RK_IPOL;
                7'h3c:   r.kind = RK_ISTAT;
                7'h40:   r.kind = RK_IEOI;
                7'h44:   r.kind = RK_IMASK;
                default: ;
            endcase
        end else begin
            case (a)
                7'h34:   r.kind = RK_IMASK;
                7'h38:   r.kind = RK_ITYPE;
                7'h3c:   r.kind = RK_IPOL;
                7'h40:   r.kind = RK_ISTAT;
                7'h4c:   r.kind = RK_IEOI;
                default: ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is guaranteed.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Move the pins through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
// Per-pin debounce filter for the interrupt-capable port.
// A pin with debounce enabled must differ from its accepted level on
// DEB_CYCLES consecutive ticks before it is accepted. A pin with debounce
// disabled is accepted every cycle. The output is always registered.
module gpio_debounce #(
    parameter int W          = 32,
    parameter int DEB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] deb_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CNT_W = $clog2(DEB_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(DEB_CYCLES - 1);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic             st_q;
        logic [CNT_W-1:0] cnt_q;

        // Accept the new level at once, or after a full run of ticks.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= 1'b0;
                cnt_q <= '0;
            end else if (!deb_en[i] || din[i] == st_q) begin
                st_q  <= din[i];
                cnt_q <= '0;
            end else if (tick) begin
                if (cnt_q == LIM) begin
                    st_q  <= din[i];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign dout[i] = st_q;

        AST_DEB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (deb_en[i] && din[i] != st_q && !(tick && cnt_q == LIM)) |=> $stable(st_q)); // R11
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Interrupt engine for the first port.
// It detects edges against the previous filtered value, latches enabled
// edges until they are cleared, evaluates level conditions directly and
// produces the masked status vector. Assumes lvl is already synchronous.
module gpio_irq_ctrl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);
    logic [W-1:0] prev_q, pend_q, hit, level_act;

    // Find edges of the selected polarity on enabled edge pins.
    always_comb begin
        hit       = typ & en & ((pol & lvl & ~prev_q) | (~pol & ~lvl & prev_q));
        level_act = ~typ & en & ~(lvl ^ pol);
        status    = (pend_q | level_act) & en & ~mask;
    end

    // Keep the previous level and the edge latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= lvl;
            pend_q <= ((pend_q & ~clr) | hit) & en & typ;
        end
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_q) & $past(en) & $past(typ) & ~$past(clr) & ~pend_q) == '0)); // R7
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((pend_q & $past(clr & ~hit)) == '0)); // R8
    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(en)) == '0)); // R10
endmodule

// File: rtl/gpio_apb_irq.sv
// GPIO controller top: APB register file, pin outputs and interrupts.
// Writes take effect in the APB access phase. Reads are combinational
// from the address. Only port 0 has interrupt and debounce logic.
// Assumes 1 <= NUM_PORTS <= 4 and 1 <= PORT_W <= 32.
module gpio_apb_irq
    import gpio_apb_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int PORT_W     = 32,
    parameter bit ALT_MAP    = 1'b0,
    parameter int DEB_CYCLES = 4
) (
    input  logic                        pclk,
    input  logic                        presetn,
    input  logic                        psel,
    input  logic                        penable,
    input  logic                        pwrite,
    input  logic [ADDR_W-1:0]           paddr,
    input  logic [BUS_W-1:0]            pwdata,
    output logic [BUS_W-1:0]            prdata,
    input  logic                        deb_tick,
    input  logic [NUM_PORTS*PORT_W-1:0] gpio_in,
    output logic [NUM_PORTS*PORT_W-1:0] gpio_out,
    output logic [NUM_PORTS*PORT_W-1:0] gpio_oe,
    output logic                        irq
);
    localparam int TOT_W = NUM_PORTS * PORT_W;

    reg_sel_t           sel;
    logic               wr_en;
    logic [PORT_W-1:0]  wval;
    logic [TOT_W-1:0]   pins_s;
    logic [PORT_W-1:0]  filt;
    logic [PORT_W-1:0]  en_q, mask_q, typ_q, pol_q, deb_q, clr, status;
    logic [BUS_W-1:0]   data_rd [MAX_PORTS];
    logic [BUS_W-1:0]   dir_rd  [MAX_PORTS];
    logic [BUS_W-1:0]   pins_rd [MAX_PORTS];

    assign sel   = decode_addr(paddr, ALT_MAP);
    assign wr_en = psel && penable && pwrite;
    assign wval  = pwdata[PORT_W-1:0];
    assign clr   = (wr_en && sel.kind == RK_IEOI) ? wval : '0;

    gpio_sync2 #(.W(TOT_W)) u_sync (
        .clk(pclk), .rst_n(presetn), .d(gpio_in), .q(pins_s)
    );

    gpio_debounce #(.W(PORT_W), .DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(pclk), .rst_n(presetn), .tick(deb_tick), .deb_en(deb_q),
        .din(pins_s[PORT_W-1:0]), .dout(filt)
    );

    gpio_irq_ctrl #(.W(PORT_W)) u_irq (
        .clk(pclk), .rst_n(presetn), .lvl(filt), .en(en_q), .mask(mask_q),
        .typ(typ_q), .pol(pol_q), .clr(clr), .status(status)
    );

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        if (p < NUM_PORTS) begin : g_on
            logic [PORT_W-1:0] dat_q, dir_q;

            // Hold this port's output value and output enable.
            always_ff @(posedge pclk) begin
                if (!presetn) begin
                    dat_q <= '0;
                    dir_q <= '0;
                end else if (wr_en && sel.port == 2'(p)) begin
                    if (sel.kind == RK_DATA) dat_q <= wval;
                    if (sel.kind == RK_DIR)  dir_q <= wval;
                end
            end

            assign gpio_out[p*PORT_W +: PORT_W] = dat_q;
            assign gpio_oe[p*PORT_W +: PORT_W]  = dir_q;
            assign data_rd[p] = BUS_W'(dat_q);
            assign dir_rd[p]  = BUS_W'(dir_q);
            assign pins_rd[p] = BUS_W'(pins_s[p*PORT_W +: PORT_W]);
        end else begin : g_off
            assign data_rd[p] = '0;
            assign dir_rd[p]  = '0;
            assign pins_rd[p] = '0;
        end
    end

    // Hold the interrupt configuration of port 0.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            en_q   <= '0;
            mask_q <= '0;
            typ_q  <= '0;
            pol_q  <= '0;
            deb_q  <= '0;
        end else if (wr_en) begin
            case (sel.kind)
                RK_IEN:   en_q   <= wval;
                RK_IMASK: mask_q <= wval;
                RK_ITYPE: typ_q  <= wval;
                RK_IPOL:  pol_q  <= wval;
                RK_IDEB:  deb_q  <= wval;
                default:  ;
            endcase
        end
    end

    // Select the read data from the decoded register.
    always_comb begin
        case (sel.kind)
            RK_DATA:  prdata = data_rd[sel.port];
            RK_DIR:   prdata = dir_rd[sel.port];
            RK_PINS:  prdata = pins_rd[sel.port];
            RK_IEN:   prdata = BUS_W'(en_q);
            RK_IMASK: prdata = BUS_W'(mask_q);
            RK_ITYPE: prdata = BUS_W'(typ_q);
            RK_IPOL:  prdata = BUS_W'(pol_q);
            RK_ISTAT: prdata = BUS_W'(status);
            RK_IDEB:  prdata = BUS_W'(deb_q);
            default:  prdata = '0;
        endcase
    end

    assign irq = |status;

    AST_DR_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && sel.kind == RK_DATA && sel.port == 2'd0)
        |=> (gpio_out[PORT_W-1:0] == $past(wval))); // R2
endmodule

// File: tb/test_gpio_apb_irq.sv
// Scoreboard bench. Read tasks push the expected data. A monitor at the
// falling edge pops each item and compares it with prdata.
module test_gpio_apb_irq;
    localparam int NP_A = 4, W_A = 32, NP_B = 2, W_B = 8;

    logic pclk = 1'b0;
    always #5 pclk = ~pclk;

    logic        presetn = 1'b0;
    logic        psel_a = 1'b0, psel_b = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [6:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata_a, prdata_b;
    logic [NP_A*W_A-1:0] gin_a = '0;
    logic [NP_A*W_A-1:0] gout_a, goe_a;
    logic [NP_B*W_B-1:0] gin_b = '0;
    logic [NP_B*W_B-1:0] gout_b, goe_b;
    logic        irq_a, irq_b;

    gpio_apb_irq #(.NUM_PORTS(NP_A), .PORT_W(W_A), .ALT_MAP(1'b0), .DEB_CYCLES(4)) i_gpio_apb_irq (
        .pclk(pclk), .presetn(presetn), .psel(psel_a), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .deb_tick(1'b1),
        .gpio_in(gin_a), .gpio_out(gout_a), .gpio_oe(goe_a), .irq(irq_a)
    );

    gpio_apb_irq #(.NUM_PORTS(NP_B), .PORT_W(W_B), .ALT_MAP(1'b1), .DEB_CYCLES(2)) i_gpio_apb_irq_alt (
        .pclk(pclk), .presetn(presetn), .psel(psel_b), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .deb_tick(1'b1),
        .gpio_in(gin_b), .gpio_out(gout_b), .gpio_oe(goe_b), .irq(irq_b)
    );

    int n_vec = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    task automatic bus(input bit b, input bit w, input logic [6:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel_a = !b; psel_b = b; pwrite = w; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge pclk); #1 penable = 1'b1;
        @(posedge pclk); #1 psel_a = 1'b0; psel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr(input bit b, input logic [6:0] a, input logic [31:0] d);
        bus(b, 1'b1, a, d);
    endtask

    task automatic rd(input bit b, input logic [6:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus(b, 1'b0, a, '0);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge pclk);
        @(negedge pclk);
    endtask

    task automatic set_a(input int pin, input logic v);
        @(posedge pclk); #1 gin_a[pin] = v;
    endtask

    task automatic pulse_a(input int pin, input int len);
        @(posedge pclk); #1 gin_a[pin] = 1'b1;
        repeat (len) @(posedge pclk);
        #1 gin_a[pin] = 1'b0;
    endtask

    // Monitor: compare each read data phase with the queued expectation.
    always @(negedge pclk) begin : monitor
        logic [31:0] got;
        if ((psel_a || psel_b) && penable && !pwrite) begin
            got = psel_b ? prdata_b : prdata_a;
            if (exp_q.size() == 0) check(got, 32'hdead_beef, "unexpected read");
            else check(got, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge pclk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(posedge pclk);
        #1 presetn = 1'b1;
        settle(1);
        // R1 reset state
        check({31'd0, irq_a}, 32'd0, "R1 irq");
        check(goe_a[31:0], 32'd0, "R1 oe");
        rd(0, 7'h00, 32'd0, "R1 data A");
        rd(0, 7'h04, 32'd0, "R1 dir A");
        rd(0, 7'h40, 32'd0, "R1 status");
        // R2 outputs and strides
        wr(0, 7'h00, 32'hA5A5_0F0F);
        wr(0, 7'h04, 32'hFFFF_0000);
        wr(0, 7'h24, 32'h1234_5678);
        wr(0, 7'h28, 32'h0000_00FF);
        settle(1);
        check(gout_a[31:0], 32'hA5A5_0F0F, "R2 out A");
        check(goe_a[31:0], 32'hFFFF_0000, "R2 oe A");
        check(gout_a[127:96], 32'h1234_5678, "R2 out D");
        check(goe_a[127:96], 32'h0000_00FF, "R2 oe D");
        rd(0, 7'h24, 32'h1234_5678, "R2 readback D");
        // R3 sampled inputs
        @(posedge pclk); #1 gin_a[63:32] = 32'hCAFE_F00D;
        settle(4);
        rd(0, 7'h54, 32'hCAFE_F00D, "R3 pins B");
        rd(0, 7'h50, 32'd0, "R3 pins A");
        // R4 level high on pin 0
        wr(0, 7'h38, 32'h0);
        wr(0, 7'h3c, 32'h1);
        wr(0, 7'h30, 32'h1);
        settle(6);
        check({31'd0, irq_a}, 32'd0, "R4 level high idle");
        set_a(0, 1'b1);
        settle(6);
        check({31'd0, irq_a}, 32'd1, "R5 irq level high");
        rd(0, 7'h40, 32'h1, "R5 status pin0");
        // R9 end-of-interrupt leaves level alone
        wr(0, 7'h4c, 32'hFFFF_FFFF);
        settle(4);
        rd(0, 7'h40, 32'h1, "R9 level survives eoi");
        set_a(0, 1'b0);
        settle(6);
        check({31'd0, irq_a}, 32'd0, "R9 level follows pin");
        // R4 level low on pin 1
        wr(0, 7'h3c, 32'h0);
        wr(0, 7'h30, 32'h2);
        settle(6);
        rd(0, 7'h40, 32'h2, "R4 level low");
        // R6 mask
        wr(0, 7'h34, 32'h2);
        settle(2);
        check({31'd0, irq_a}, 32'd0, "R6 masked irq");
        rd(0, 7'h40, 32'h0, "R6 masked status");
        wr(0, 7'h34, 32'h0);
        settle(2);
        check({31'd0, irq_a}, 32'd1, "R6 unmask returns");
        set_a(1, 1'b1);
        settle(6);
        check({31'd0, irq_a}, 32'd0, "R5 level low released");
        // R7 rising edge on pin 2
        wr(0, 7'h38, 32'h4);
        wr(0, 7'h3c, 32'h4);
        wr(0, 7'h30, 32'h4);
        pulse_a(2, 8);
        settle(6);
        check({31'd0, irq_a}, 32'd1, "R7 edge latched");
        rd(0, 7'h40, 32'h4, "R7 status");
        // R8 end-of-interrupt clears
        wr(0, 7'h4c, 32'h4);
        settle(2);
        check({31'd0, irq_a}, 32'd0, "R8 eoi clears");
        // R4 falling edge on pin 3, rising ignored
        wr(0, 7'h38, 32'hC);
        wr(0, 7'h3c, 32'h4);
        wr(0, 7'h30, 32'hC);
        set_a(3, 1'b1);
        settle(8);
        rd(0, 7'h40, 32'h0, "R4 rising ignored on falling pin");
        set_a(3, 1'b0);
        pulse_a(2, 8);
        settle(6);
        rd(0, 7'h40, 32'hC, "R4 falling and rising pending");
        wr(0, 7'h4c, 32'h4);
        settle(2);
        rd(0, 7'h40, 32'h8, "R8 selective eoi");
        wr(0, 7'h4c, 32'hFFFF_FFFF);
        settle(2);
        rd(0, 7'h40, 32'h0, "R8 all-ones eoi");
        // R10 disabling drops a pending edge
        pulse_a(2, 8);
        settle(6);
        rd(0, 7'h40, 32'h4, "R10 pending before disable");
        wr(0, 7'h30, 32'h0);
        settle(2);
        check({31'd0, irq_a}, 32'd0, "R10 disabled");
        wr(0, 7'h30, 32'h4);
        settle(2);
        rd(0, 7'h40, 32'h0, "R10 no stale edge");
        // R11 debounce on pin 4
        wr(0, 7'h38, 32'h10);
        wr(0, 7'h3c, 32'h10);
        wr(0, 7'h48, 32'h10);
        wr(0, 7'h30, 32'h10);
        pulse_a(4, 2);
        settle(12);
        rd(0, 7'h40, 32'h0, "R11 glitch rejected");
        rd(0, 7'h48, 32'h10, "R11 debounce readback");
        set_a(4, 1'b1);
        settle(12);
        rd(0, 7'h40, 32'h10, "R11 long level accepted");
        // R12 alternate map on the second instance
        wr(1, 7'h34, 32'h1);
        wr(1, 7'h38, 32'h1);
        wr(1, 7'h30, 32'h1);
        @(posedge pclk); #1 gin_b[0] = 1'b1;
        settle(8);
        @(posedge pclk); #1 gin_b[0] = 1'b0;
        settle(8);
        check({31'd0, irq_b}, 32'd1, "R12 alt edge irq");
        rd(1, 7'h3c, 32'h1, "R12 alt status");
        rd(1, 7'h34, 32'h1, "R12 alt type");
        wr(1, 7'h44, 32'h1);
        settle(2);
        check({31'd0, irq_b}, 32'd0, "R12 alt mask");
        wr(1, 7'h44, 32'h0);
        wr(1, 7'h40, 32'h1);
        settle(2);
        rd(1, 7'h3c, 32'h0, "R12 alt eoi");
        // R13 absent and narrow ports
        wr(1, 7'h18, 32'hFF);
        rd(1, 7'h18, 32'h0, "R13 absent port");
        wr(1, 7'h0c, 32'hABCD);
        settle(1);
        check({24'd0, gout_b[15:8]}, 32'hCD, "R13 narrow out");
        rd(1, 7'h0c, 32'hCD, "R13 narrow readback");
        settle(2);
        check(exp_q.size(), 32'd0, "scoreboard drained");
        finish_run();
    end
endmodule